// File: doc/BRIEF.md
# Address-Shared Bidirectional Port Pair

This block provides two byte-wide bidirectional pin groups, called the high port and the low port. Each has a latch register and a direction register, and both are reached over a small register bus. When the chip runs on its own, every pin is general-purpose I/O. Each pin then drives its latch bit whenever its direction bit is set, and otherwise samples the pad.

When the chip uses external memory, the pins are taken over to carry a 16-bit external address. The high port carries the upper byte and the low port carries the lower byte. The lowest pin of the low port is special: in one expanded mode it carries a byte-lane strobe instead of address bit 0.

In the debug-mirroring mode, the register accesses are also sent to the external bus. A write is presented on a mirror strobe together with its data and offset. A read returns the byte supplied from outside rather than the internal value. The pads themselves are modelled as separate output, output-enable and input vectors.

Top module: `addr_gpio_pair`

## Requirements
- R1: After reset, every latch and direction register holds 0x00, so every pad output enable is 0 in standalone mode.
- R2: A register write at offset 0 (high latch), 1 (low latch), 2 (high direction) or 3 (low direction) can happen in any cycle and in any mode. A read of that offset returns the written byte, with the read data appearing in the cycle after the read strobe.
- R3: A latch read returns, bit by bit, the latch bit where the direction bit is 1 and the synchronized pad level where it is 0.
- R4: A change on a pad input reaches read data only after two clock edges of synchronization. Reads captured at the first two edges after the change still return the old level.
- R5: In standalone mode (mode code 0), each pad output enable equals its direction bit and each pad output equals its latch bit.
- R6: In mode codes 1, 2 and 3, the high port drives address bits 15..8 (pin 7 carries bit 15), with all output enables forced to 1 whatever the direction bits hold.
- R7: In mode codes 1, 2 and 3, low-port pins 7..1 drive address bits 7..1, with their output enables forced to 1.
- R8: Low-port pin 0 is also forced on in those modes. It drives the byte-lane strobe input in mode code 1 (normal expanded) and address bit 0 in mode codes 2 (special test) and 3 (mirroring).
- R9: In mode code 3, a read of offsets 0..3 returns the external read byte sampled on the read edge and raises the mirror read strobe during that cycle.
- R10: In mode code 3, a write of offsets 0..3 raises the mirror write strobe during that cycle, presents the offset and data on the mirror outputs, and still updates the internal register.
- R11: Offsets 4..7 read as 0x00, and writes to them change no register.
- R12: Mode codes 4..7 behave exactly as standalone mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Operating mode code (0 standalone, 1 normal expanded, 2 special test, 3 mirroring) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_off | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| bus_addr | input | 16 | External address from the bus engine |
| lane_strobe | input | 1 | Byte-lane strobe for low pin 0 in normal expanded mode |
| mir_rdata | input | 8 | Byte returned by the external bus for mirrored reads |
| mir_we | output | 1 | Mirrored write strobe |
| mir_re | output | 1 | Mirrored read strobe |
| mir_off | output | 2 | Offset of the mirrored access |
| mir_wdata | output | 8 | Data of the mirrored write |
| pa_out | output | 8 | High port pad outputs |
| pa_oe | output | 8 | High port pad output enables |
| pa_in | input | 8 | High port pad inputs |
| pb_out | output | 8 | Low port pad outputs |
| pb_oe | output | 8 | Low port pad output enables |
| pb_in | input | 8 | Low port pad inputs |

## Verification
The hardest case to reach from the ports is the two-edge synchronizer window. Observing it needs a pad change and back-to-back reads whose capture edges fall exactly on the first, second and third edges after the change. The bench changes the pad on the same falling edge that raises the first read strobe, then issues two more reads in a row. It expects old, old and then new data. A second hard case is proving that a mirrored write also reached the internal register. That register is hidden while mirroring, so the bench returns to standalone mode and recovers the value through the direction-dependent read mix.

// File: rtl/agp_pkg.sv
package agp_pkg;

  localparam int BYTE_W  = 8;
  localparam int NUM_REG = 4;

  typedef enum logic [1:0] {
    PM_SINGLE = 2'd0,
    PM_NEXP   = 2'd1,
    PM_STEST  = 2'd2,
    PM_MIRROR = 2'd3
  } port_mode_e;

  typedef enum logic [1:0] {
    OFF_HI_DATA = 2'd0,
    OFF_LO_DATA = 2'd1,
    OFF_HI_DIR  = 2'd2,
    OFF_LO_DIR  = 2'd3
  } reg_sel_e;

  // Codes above 3 fall back to standalone operation.
  function automatic port_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    return PM_NEXP;
      3'd2:    return PM_STEST;
      3'd3:    return PM_MIRROR;
      default: return PM_SINGLE;
    endcase
  endfunction

  function automatic logic bus_owns_pins(input port_mode_e m);
    return m != PM_SINGLE;
  endfunction

  function automatic logic pin0_carries_addr(input port_mode_e m);
    return (m == PM_STEST) || (m == PM_MIRROR);
  endfunction

  // Driven pins read back the latch; undriven pins read the pad.
  function automatic logic read_mix_bit(input logic dir, input logic latch,
                                        input logic pad);
    return dir ? latch : pad;
  endfunction

endpackage

// File: rtl/agp_sync.sv
module agp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

  // R4: the output only ever takes the previous value of the stage before it
  a_r4_sync_chain: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sync_o == $past(stage_q[STAGES-2]));

endmodule

// File: rtl/agp_port.sv
module agp_port
  import agp_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_latch,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] claim_mask,
  input  logic [W-1:0] claim_val,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] rd_latch,
  output logic [W-1:0] rd_dir
);

  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] pad_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_latch) latch_q <= wdata;
      if (wr_dir)   dir_q   <= wdata;
    end
  end

  agp_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(pad_in),
    .sync_o (pad_s)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      pad_out[i]  = claim_mask[i] ? claim_val[i] : latch_q[i];
      pad_oe[i]   = claim_mask[i] | dir_q[i];
      rd_latch[i] = read_mix_bit(dir_q[i], latch_q[i], pad_s[i]);
    end
  end

  assign rd_dir = dir_q;

  // R2: a write lands in the register on the next edge
  a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_latch |=> latch_q == $past(wdata));
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata));
  // R5: unclaimed pins follow their own registers
  a_r5_free_pins: assert property (@(posedge clk) disable iff (!rst_n)
    claim_mask == '0 |-> (pad_oe == dir_q) && (pad_out == latch_q));

endmodule

// File: rtl/addr_gpio_pair.sv
module addr_gpio_pair
  import agp_pkg::*;
#(
  parameter int W           = BYTE_W,
  parameter int OFF_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [2*W-1:0]    bus_addr,
  input  logic              lane_strobe,
  input  logic [W-1:0]      mir_rdata,
  output logic              mir_we,
  output logic              mir_re,
  output logic [1:0]        mir_off,
  output logic [W-1:0]      mir_wdata,
  output logic [W-1:0]      pa_out,
  output logic [W-1:0]      pa_oe,
  input  logic [W-1:0]      pa_in,
  output logic [W-1:0]      pb_out,
  output logic [W-1:0]      pb_oe,
  input  logic [W-1:0]      pb_in
);

  localparam int ADDR_W = 2 * W;

  port_mode_e   pmode;
  logic         bus_claim;
  logic         mirror_on;
  logic         off_valid;
  reg_sel_e     sel;
  logic [W-1:0] claim_mask;
  logic [W-1:0] hi_val;
  logic [W-1:0] lo_val;
  logic         pin0_src;
  logic [W-1:0] hi_rd_latch, hi_rd_dir;
  logic [W-1:0] lo_rd_latch, lo_rd_dir;
  logic [W-1:0] local_rd;
  logic         wr_hi_latch, wr_lo_latch, wr_hi_dir, wr_lo_dir;

  always_comb begin
    pmode      = decode_mode(mode);
    bus_claim  = bus_owns_pins(pmode);
    mirror_on  = (pmode == PM_MIRROR);
    off_valid  = (reg_off < OFF_W'(NUM_REG));
    sel        = reg_sel_e'(reg_off[1:0]);
    claim_mask = bus_claim ? '1 : '0;
    hi_val     = bus_addr[ADDR_W-1:W];
    pin0_src   = pin0_carries_addr(pmode) ? bus_addr[0] : lane_strobe;
    lo_val     = {bus_addr[W-1:1], pin0_src};
  end

  assign wr_hi_latch = reg_wr && off_valid && (sel == OFF_HI_DATA);
  assign wr_lo_latch = reg_wr && off_valid && (sel == OFF_LO_DATA);
  assign wr_hi_dir   = reg_wr && off_valid && (sel == OFF_HI_DIR);
  assign wr_lo_dir   = reg_wr && off_valid && (sel == OFF_LO_DIR);

  agp_port #(.W(W), .SYNC_STAGES(SYNC_STAGES)) i_port_hi (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_latch  (wr_hi_latch),
    .wr_dir    (wr_hi_dir),
    .wdata     (reg_wdata),
    .claim_mask(claim_mask),
    .claim_val (hi_val),
    .pad_in    (pa_in),
    .pad_out   (pa_out),
    .pad_oe    (pa_oe),
    .rd_latch  (hi_rd_latch),
    .rd_dir    (hi_rd_dir)
  );

  agp_port #(.W(W), .SYNC_STAGES(SYNC_STAGES)) i_port_lo (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_latch  (wr_lo_latch),
    .wr_dir    (wr_lo_dir),
    .wdata     (reg_wdata),
    .claim_mask(claim_mask),
    .claim_val (lo_val),
    .pad_in    (pb_in),
    .pad_out   (pb_out),
    .pad_oe    (pb_oe),
    .rd_latch  (lo_rd_latch),
    .rd_dir    (lo_rd_dir)
  );

  always_comb begin
    case (sel)
      OFF_HI_DATA: local_rd = hi_rd_latch;
      OFF_LO_DATA: local_rd = lo_rd_latch;
      OFF_HI_DIR:  local_rd = hi_rd_dir;
      default:     local_rd = lo_rd_dir;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         reg_rdata <= '0;
    else if (reg_rd) begin
      if (!off_valid)     reg_rdata <= '0;
      else if (mirror_on) reg_rdata <= mir_rdata;
      else                reg_rdata <= local_rd;
    end
  end

  assign mir_we    = reg_wr && off_valid && mirror_on;
  assign mir_re    = reg_rd && off_valid && mirror_on;
  assign mir_off   = reg_off[1:0];
  assign mir_wdata = reg_wdata;

  // R6: high port carries the upper address byte
  a_r6_high_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (mode inside {3'd1, 3'd2, 3'd3}) |-> (pa_oe == '1) && (pa_out == bus_addr[ADDR_W-1:W]));
  // R7: low port pins above 0 carry the lower address bits
  a_r7_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (mode inside {3'd1, 3'd2, 3'd3}) |-> (pb_oe == '1) && (pb_out[W-1:1] == bus_addr[W-1:1]));
  // R8: pin 0 role per mode
  a_r8_pin0_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> pb_out[0] == lane_strobe);
  a_r8_pin0_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mode inside {3'd2, 3'd3}) |-> pb_out[0] == bus_addr[0]);
  // R9: mirrored read returns the external byte
  a_r9_mirror_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && mode == 3'd3 && reg_off < 3'd4) |=> reg_rdata == $past(mir_rdata));
  // R10: mirrored write is presented outside
  a_r10_mirror_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && mode == 3'd3 && reg_off < 3'd4) |-> mir_we && (mir_wdata == reg_wdata));
  // R11: unused offsets read zero
  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_off >= 3'd4) |=> reg_rdata == '0);

endmodule

// File: tb/test_addr_gpio_pair.sv
module test_addr_gpio_pair;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_off;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [15:0] bus_addr;
  logic        lane_strobe;
  logic [7:0]  mir_rdata, mir_wdata;
  logic        mir_we, mir_re;
  logic [1:0]  mir_off;
  logic [7:0]  pa_out, pa_oe, pa_in, pb_out, pb_oe, pb_in;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  bit rd_seen = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_gpio_pair i_addr_gpio_pair (
    .clk(clk), .rst_n(rst_n), .mode(mode), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_addr(bus_addr), .lane_strobe(lane_strobe), .mir_rdata(mir_rdata),
    .mir_we(mir_we), .mir_re(mir_re), .mir_off(mir_off), .mir_wdata(mir_wdata),
    .pa_out(pa_out), .pa_oe(pa_oe), .pa_in(pa_in),
    .pb_out(pb_out), .pb_oe(pb_oe), .pb_in(pb_in)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] off, input logic [7:0] d);
    reg_off = off; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // driver: pushes the expected byte, the monitor pops it one cycle later
  task automatic rd(input logic [2:0] off, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_off = off; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= reg_rd && rst_n;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 16'd1, 16'd0);
      else chk(tag_q.pop_front(), {8'h0, reg_rdata}, {8'h0, exp_q.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 16'd1, 16'd0);
    finish_run();
  end

  initial begin
    rst_n = 0; mode = 3'd0; reg_wr = 0; reg_rd = 0; reg_off = 0; reg_wdata = 0;
    bus_addr = 0; lane_strobe = 0; mir_rdata = 0; pa_in = 0; pb_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pa_oe", {8'h0, pa_oe}, 16'h0);
    chk("R1 pb_oe", {8'h0, pb_oe}, 16'h0);
    rd(3'd2, 8'h00, "R1 hi dir");
    rd(3'd1, 8'h00, "R1 lo latch");

    // R2 / R5 / R3 on high port
    wr(3'd2, 8'hF0);
    wr(3'd0, 8'hA5);
    rd(3'd2, 8'hF0, "R2 hi dir readback");
    chk("R5 pa_oe", {8'h0, pa_oe}, 16'h00F0);
    chk("R5 pa_out", {8'h0, pa_out}, 16'h00A5);
    pa_in = 8'h3C;
    repeat (2) @(negedge clk);
    rd(3'd0, 8'hAC, "R3 hi mix");

    // R3 on low port
    wr(3'd3, 8'h0F);
    wr(3'd1, 8'h5A);
    pb_in = 8'hFF;
    repeat (2) @(negedge clk);
    rd(3'd1, 8'hFA, "R3 lo mix");
    rd(3'd3, 8'h0F, "R2 lo dir readback");

    // R4 synchronizer window
    wr(3'd2, 8'h00);
    pa_in = 8'h00;
    repeat (2) @(negedge clk);
    rd(3'd0, 8'h00, "R3 all inputs");
    pa_in = 8'h77;
    rd(3'd0, 8'h00, "R4 first edge old");
    rd(3'd0, 8'h00, "R4 second edge old");
    rd(3'd0, 8'h77, "R4 third edge new");

    // R11 unused offsets
    wr(3'd5, 8'hFF);
    wr(3'd7, 8'hFF);
    rd(3'd2, 8'h00, "R11 hi dir untouched");
    rd(3'd3, 8'h0F, "R11 lo dir untouched");
    rd(3'd6, 8'h00, "R11 unused read");

    // R6 / R7 / R8 expanded modes
    mode = 3'd1; bus_addr = 16'h1234; lane_strobe = 1'b1;
    #1;
    chk("R6 pa_out", {8'h0, pa_out}, 16'h0012);
    chk("R6 pa_oe", {8'h0, pa_oe}, 16'h00FF);
    chk("R8 pb_out strobe 1", {8'h0, pb_out}, 16'h0035);
    chk("R7 pb_oe", {8'h0, pb_oe}, 16'h00FF);
    lane_strobe = 1'b0;
    #1;
    chk("R8 pb_out strobe 0", {8'h0, pb_out}, 16'h0034);
    @(negedge clk);
    mode = 3'd2; bus_addr = 16'hABCD;
    #1;
    chk("R7 pb_out test mode", {8'h0, pb_out}, 16'h00CD);
    chk("R6 pa_out test mode", {8'h0, pa_out}, 16'h00AB);
    @(negedge clk);

    // R9 / R10 mirroring mode
    mode = 3'd3; bus_addr = 16'h0001; lane_strobe = 1'b0;
    #1;
    chk("R8 pin0 addr in mirror", {15'h0, pb_out[0]}, 16'h1);
    @(negedge clk);
    mir_rdata = 8'h9E;
    reg_off = 3'd2; reg_rd = 1'b1;
    exp_q.push_back(8'h9E); tag_q.push_back("R9 mirror read");
    #1;
    chk("R9 mir_re", {15'h0, mir_re}, 16'h1);
    @(negedge clk);
    reg_rd = 1'b0;
    reg_off = 3'd1; reg_wdata = 8'h3C; reg_wr = 1'b1;
    #1;
    chk("R10 mir_we", {15'h0, mir_we}, 16'h1);
    chk("R10 mir_off", {14'h0, mir_off}, 16'h1);
    chk("R10 mir_wdata", {8'h0, mir_wdata}, 16'h003C);
    @(negedge clk);
    reg_wr = 1'b0;

    // R10 internal update seen back in standalone mode
    mode = 3'd0;
    rd(3'd1, 8'hFC, "R10 internal latch written");

    // R12 upper mode codes act as standalone
    mode = 3'd5;
    #1;
    chk("R12 pa_oe", {8'h0, pa_oe}, 16'h0000);
    chk("R12 pb_oe", {8'h0, pb_oe}, 16'h000F);
    chk("R12 pb_out", {8'h0, pb_out}, 16'h003C);
    @(negedge clk);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 16'd0);
    finish_run();
  end

endmodule